// File: doc/BRIEF.md
# Buck-Boost Four-Switch Gate Sequencer

This block produces the four gate-enable signals of a bidirectional buck-boost power stage. The four switches are the buck high-side, the buck low-side, the boost switch and the charge switch. Two mode inputs choose one of three operations. In step-down, energy flows from the battery to the bus. In step-up, the bus is driven above the battery. In charge, energy flows from the bus back into the battery. A free-running counter defines a fixed switching period. Inside each period, one programmable on-time phase D and its complement D' are separated by dead intervals.

Each period starts with a dead interval. The D phase follows, then a second dead interval, then D' until the period ends. The duty command and the mode are sampled only at a period boundary. A per-mode table then steers D and D' onto the four outputs, so switches that do not toggle in a mode are held at a constant level.

Two overcurrent flags cover the forward and reverse directions. Either flag turns off both phases of the switching pair. The shutdown lasts until the next period boundary at which no flag is raised. All outputs are registered.

Top module: `bbg_gate_seq`

## Requirements
- R1: Mode bits {mode_up, mode_chg} = 00 select step-down: g_hs follows D, g_ls follows D', g_bst stays low and g_chg stays high.
- R2: Mode bits 10 select step-up: g_hs stays high, g_ls stays low, g_bst follows D and g_chg follows D'.
- R3: Mode bits 01 select charge: g_hs stays high, g_ls stays low, g_chg follows D and g_bst follows D'.
- R4: Every period begins with DEAD cycles in which neither D nor D' is active, and another DEAD cycles separate the end of D from the start of D'. The two switches of a complementary pair are never high together.
- R5: The period is PERIOD clock cycles. D lasts exactly the latched on-time, and D' fills the rest of the period after both dead intervals.
- R6: A duty command above PERIOD-2*DEAD is clamped to PERIOD-2*DEAD, which leaves D' empty.
- R7: Duty and mode inputs are sampled only on the last cycle of a period. A change in mid-period has no effect until the next period.
- R8: Mode bits 11 drive all four outputs low for the whole period that latched them.
- R9: While reset is held, and during the first cycle after it is released, all four outputs are low.
- R10: A high oc_fwd or oc_rev forces D and D' off from the next output update. The shutdown holds for the rest of the period and is released at the next boundary only if both flags are low.
- R11: A switch that is meant to stay off in the selected mode never asserts, even when the duty command is 0 or at the clamp limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_up | input | 1 | Mode bit 1 (step-up when set alone) |
| mode_chg | input | 1 | Mode bit 0 (charge when set alone) |
| duty | input | CW | Requested D on-time in clock cycles |
| oc_fwd | input | 1 | Forward-direction overcurrent flag |
| oc_rev | input | 1 | Reverse-direction overcurrent flag |
| g_hs | output | 1 | Buck high-side gate enable |
| g_ls | output | 1 | Buck low-side gate enable |
| g_bst | output | 1 | Boost switch gate enable |
| g_chg | output | 1 | Charge switch gate enable |

## Verification
The bench builds the block with PERIOD=24 and DEAD=2, so the duty port is 5 bits wide. This puts the clamp at 20, below the port maximum of 31, so both clamped and unclamped commands are reachable. It also makes periods short enough that thousands of cycles cover hundreds of boundaries. At those boundaries the bench exercises mode switches, illegal modes, shutdowns that span a boundary and mid-period duty changes. A cycle-accurate shadow model checks all four outputs on every cycle, and directed windows measure on-time, dead time and clamp lengths.

// File: rtl/bbg_pkg.sv
package bbg_pkg;

  // mode word is {mode_up, mode_chg}
  typedef enum logic [1:0] {
    BBG_DOWN = 2'b00,
    BBG_CHG  = 2'b01,
    BBG_UP   = 2'b10,
    BBG_BAD  = 2'b11
  } bbg_mode_e;

  // longest D on-time that still leaves both dead intervals
  function automatic int unsigned clamp_on(int unsigned req, int unsigned per,
                                           int unsigned dt);
    int unsigned lim;
    lim = per - 2 * dt;
    return (req > lim) ? lim : req;
  endfunction

  // D window: [dt, dt+n)
  function automatic logic in_d(int unsigned cnt, int unsigned n, int unsigned dt);
    return (cnt >= dt) && (cnt < dt + n);
  endfunction

  // D' window: [2*dt+n, end of period)
  function automatic logic in_dp(int unsigned cnt, int unsigned n, int unsigned dt);
    return cnt >= (2 * dt + n);
  endfunction

endpackage

// File: rtl/bbg_period_timer.sv
module bbg_period_timer
  import bbg_pkg::*;
#(
  parameter int unsigned PERIOD = 1000,
  parameter int unsigned DEAD   = 10,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_up,
  input  logic          mode_chg,
  input  logic [CW-1:0] duty,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] on_n,
  output bbg_mode_e     mode_q,
  output logic          valid_q,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= LAST;
      on_n    <= '0;
      mode_q  <= BBG_BAD;
      valid_q <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      on_n    <= CW'(clamp_on(32'(duty), PERIOD, DEAD));
      mode_q  <= bbg_mode_e'({mode_up, mode_chg});
      valid_q <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < PERIOD);                                                    // R5
  AST_ONTIME_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    32'(on_n) <= PERIOD - 2 * DEAD);                                      // R6
  AST_LATCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(on_n) && $stable(mode_q)));                         // R7

endmodule

// File: rtl/bbg_phase_gen.sv
module bbg_phase_gen
  import bbg_pkg::*;
#(
  parameter int unsigned DEAD = 10,
  parameter int unsigned CW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on_n,
  input  logic          trip,
  output logic          ph_d,
  output logic          ph_dp
);

  assign ph_d  = in_d(32'(cnt), 32'(on_n), DEAD)  && !trip;
  assign ph_dp = in_dp(32'(cnt), 32'(on_n), DEAD) && !trip;

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_d && ph_dp));                                                     // R4
  AST_DEAD_AFTER_D: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_d) |-> !ph_dp);                                               // R4
  AST_DEAD_AFTER_DP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_dp) |-> !ph_d);                                               // R4

endmodule

// File: rtl/bbg_oc_guard.sv
module bbg_oc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_fwd,
  input  logic oc_rev,
  input  logic wrap,
  output logic trip
);

  logic oc_any;
  logic hold;

  assign oc_any = oc_fwd | oc_rev;
  assign trip   = oc_any | hold;

  always_ff @(posedge clk) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= oc_any | (hold & ~wrap);
  end

  AST_OC_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_any && !wrap) |=> trip);                                           // R10

endmodule

// File: rtl/bbg_switch_map.sv
module bbg_switch_map
  import bbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bbg_mode_e mode_q,
  input  logic      valid_q,
  input  logic      ph_d,
  input  logic      ph_dp,
  output logic      g_hs,
  output logic      g_ls,
  output logic      g_bst,
  output logic      g_chg
);

  logic [3:0] nxt;  // {hs, ls, bst, chg}

  always_comb begin
    nxt = 4'b0000;
    if (valid_q) begin
      unique case (mode_q)
        BBG_DOWN: nxt = {ph_d, ph_dp, 1'b0, 1'b1};
        BBG_UP:   nxt = {1'b1, 1'b0, ph_d, ph_dp};
        BBG_CHG:  nxt = {1'b1, 1'b0, ph_dp, ph_d};
        default:  nxt = 4'b0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) {g_hs, g_ls, g_bst, g_chg} <= 4'b0000;
    else        {g_hs, g_ls, g_bst, g_chg} <= nxt;
  end

endmodule

// File: rtl/bbg_gate_seq.sv
module bbg_gate_seq
  import bbg_pkg::*;
#(
  parameter int unsigned PERIOD = 1000,
  parameter int unsigned DEAD   = 10,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_up,
  input  logic          mode_chg,
  input  logic [CW-1:0] duty,
  input  logic          oc_fwd,
  input  logic          oc_rev,
  output logic          g_hs,
  output logic          g_ls,
  output logic          g_bst,
  output logic          g_chg
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] on_n;
  bbg_mode_e     mode_q;
  logic          valid_q;
  logic          wrap;
  logic          trip;
  logic          ph_d;
  logic          ph_dp;

  bbg_period_timer #(.PERIOD(PERIOD), .DEAD(DEAD), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .mode_up(mode_up), .mode_chg(mode_chg),
    .duty(duty), .cnt(cnt), .on_n(on_n), .mode_q(mode_q),
    .valid_q(valid_q), .wrap(wrap)
  );

  bbg_oc_guard u_guard (
    .clk(clk), .rst_n(rst_n), .oc_fwd(oc_fwd), .oc_rev(oc_rev),
    .wrap(wrap), .trip(trip)
  );

  bbg_phase_gen #(.DEAD(DEAD), .CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .on_n(on_n), .trip(trip),
    .ph_d(ph_d), .ph_dp(ph_dp)
  );

  bbg_switch_map u_map (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .valid_q(valid_q),
    .ph_d(ph_d), .ph_dp(ph_dp),
    .g_hs(g_hs), .g_ls(g_ls), .g_bst(g_bst), .g_chg(g_chg)
  );

  AST_NO_SHOOT_BUCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_hs && g_ls));                                                      // R4
  AST_NO_SHOOT_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_bst && g_chg));                                                    // R4
  AST_OC_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fwd || oc_rev) |=> (!g_ls && !g_bst));                             // R10
  AST_BAD_MODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode_up && mode_chg) |=> ##1 (!g_hs && !g_ls && !g_bst && !g_chg)); // R8

endmodule

// File: tb/bbg_gate_seq_test.sv
`timescale 1ns/1ps
module bbg_gate_seq_test;

  localparam int P  = 24;
  localparam int DT = 2;
  localparam int CW = 5;
  localparam int LIM = P - 2 * DT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_up = 1'b0, mode_chg = 1'b0;
  logic [CW-1:0] duty = '0;
  logic oc_fwd = 1'b0, oc_rev = 1'b0;
  logic g_hs, g_ls, g_bst, g_chg;

  int checks = 0;
  int failures = 0;
  bit check_en = 0;
  bit done = 0;

  bbg_gate_seq #(.PERIOD(P), .DEAD(DT), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_up(mode_up), .mode_chg(mode_chg),
    .duty(duty), .oc_fwd(oc_fwd), .oc_rev(oc_rev),
    .g_hs(g_hs), .g_ls(g_ls), .g_bst(g_bst), .g_chg(g_chg)
  );

  always #2.5 clk = ~clk;

  // ---------------- shadow model ----------------
  int         m_cnt, m_n;
  logic [1:0] m_mode;
  logic       m_valid, m_hold;
  logic [3:0] exp_g;
  string      exp_tag;

  function automatic int clamp_b(int d);
    return (d > LIM) ? LIM : d;
  endfunction

  // expected {hs, ls, bst, chg} from position inside the period
  function automatic logic [3:0] gates_b(int c, int n, logic [1:0] md, logic v, logic trip);
    int rel;
    logic d, dp;
    rel = c - DT;
    d  = (rel >= 0) && (rel < n) && !trip;
    dp = ((rel - n) >= DT) && !trip;
    if (!v) return 4'b0000;
    case (md)
      2'b00:   return {d, dp, 1'b0, 1'b1};
      2'b10:   return {1'b1, 1'b0, d, dp};
      2'b01:   return {1'b1, 1'b0, dp, d};
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk) begin
    logic trip_b;
    if (!rst_n) begin
      m_cnt = P - 1; m_n = 0; m_mode = 2'b11; m_valid = 0; m_hold = 0;
      exp_g = 4'b0000; exp_tag = "R9";
    end else begin
      trip_b = oc_fwd | oc_rev | m_hold;
      exp_g = gates_b(m_cnt, m_n, m_mode, m_valid, trip_b);
      if (!m_valid)                    exp_tag = "R9";
      else if (trip_b)                 exp_tag = "R10";
      else if (m_mode == 2'b11)        exp_tag = "R8";
      else if (m_n != clamp_b(int'(duty))) exp_tag = "R7";
      else if (m_mode == 2'b00)        exp_tag = "R1";
      else if (m_mode == 2'b10)        exp_tag = "R2";
      else                             exp_tag = "R3";
      m_hold = (oc_fwd | oc_rev) | (m_hold & (m_cnt != P - 1));
      if (m_cnt == P - 1) begin
        m_cnt = 0; m_n = clamp_b(int'(duty)); m_mode = {mode_up, mode_chg}; m_valid = 1;
      end else m_cnt = m_cnt + 1;
    end
  end

  task automatic check(string req, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (check_en && !done) check(exp_tag, int'({g_hs, g_ls, g_bst, g_chg}), int'(exp_g), "cycle gates");
  end

  // ---------------- helpers ----------------
  task automatic set_mode(logic up, logic chg, int d);
    mode_up = up; mode_chg = chg; duty = CW'(d);
  endtask

  task automatic window(output int hs, output int ls, output int bst, output int chg, output int off);
    hs = 0; ls = 0; bst = 0; chg = 0; off = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      hs += g_hs; ls += g_ls; bst += g_bst; chg += g_chg;
      if (!g_hs && !g_ls) off++;
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int hs, ls, bst, chg, off, run;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R9", int'({g_hs, g_ls, g_bst, g_chg}), 0, "gates in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'({g_hs, g_ls, g_bst, g_chg}), 0, "gates first cycle after reset");
    check_en = 1;

    // step-down, duty 5
    set_mode(0, 0, 5);
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R5", hs, 5, "step-down hs on-time");
    check("R1", ls, LIM - 5, "step-down ls on-time");
    check("R1", chg, P, "step-down chg held");
    check("R11", bst, 0, "step-down bst held off");
    check("R4", off, 2 * DT, "step-down dead cycles");

    // clamp
    set_mode(0, 0, 31);
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R6", hs, LIM, "clamped hs on-time");
    check("R6", ls, 0, "clamped ls on-time");

    // step-up, duty 0
    set_mode(1, 0, 0);
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R11", bst, 0, "step-up zero duty bst");
    check("R2", chg, LIM, "step-up chg D'");
    check("R2", hs, P, "step-up hs held");
    check("R11", ls, 0, "step-up ls held off");

    // charge, duty 7
    set_mode(0, 1, 7);
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R3", chg, 7, "charge chg D");
    check("R3", bst, LIM - 7, "charge bst D'");
    check("R3", hs, P, "charge hs held");

    // illegal
    set_mode(1, 1, 9);
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R8", hs + ls + bst + chg, 0, "illegal mode gates");

    // mid-period duty change
    set_mode(0, 0, 5);
    repeat (2 * P) @(negedge clk);
    while (!g_hs) @(negedge clk);
    duty = CW'(15);
    run = 0;
    while (g_hs) begin run++; @(negedge clk); end
    check("R7", run, 5, "on-time after mid-period duty change");
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R7", hs, 15, "new duty next period");

    // overcurrent pulse during D
    set_mode(0, 0, 10);
    repeat (2 * P) @(negedge clk);
    while (!g_hs) @(negedge clk);
    @(negedge clk);
    oc_rev = 1'b1;
    @(negedge clk);
    oc_rev = 1'b0;
    run = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      run += g_hs + g_ls;
    end
    check("R10", run, 0, "switching pair held off after trip");
    repeat (2 * P) @(negedge clk);
    window(hs, ls, bst, chg, off);
    check("R10", hs, 10, "released after boundary");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      oc_fwd = ($urandom_range(0, 59) == 0);
      oc_rev = ($urandom_range(0, 79) == 0);
      if ($urandom_range(0, 19) == 0) duty = CW'($urandom_range(0, 31));
      if ($urandom_range(0, 39) == 0) begin
        case ($urandom_range(0, 7))
          0:       begin mode_up = 1; mode_chg = 1; end
          1, 2:    begin mode_up = 1; mode_chg = 0; end
          3, 4:    begin mode_up = 0; mode_chg = 1; end
          default: begin mode_up = 0; mode_chg = 0; end
        endcase
      end
    end
    oc_fwd = 0; oc_rev = 0;
    repeat (P) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule